// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Converter Code Bank

This block sits between a serial command receiver and a two-channel converter. Each channel has two register stages. The staging register takes a word each time the receiver reports a completed write for that channel. The live register drives the converter and reloads from the staging register only while the load request is active. Each stored word is a 12-bit code, a gain bit and a 2-bit power-mode field.

The load request is a level, not an edge. While it is held active, each live register follows its staging register. A channel reloads only when its staging register has been written since its live register last took a value. A channel that has not been written keeps its live word, and no update pulse is raised for it. A separate active-low clear input empties both stages of both channels at once, with no clock needed. A synchronous active-high reset returns the whole block to its idle state.

Top module: `dac_dual_buffer`

## Requirements
- R1: With `rst` high at a rising edge, every register is cleared. After that edge all outputs read zero, `dac_upd` is low, and no channel is pending.
- R2: A write (`wr_en` high at a rising edge) loads `{wr_gain, wr_pmode, wr_code}` into the staging register of one channel only. `wr_sel` = 0 selects channel A, which is the low slices of the outputs. `wr_sel` = 1 selects channel B.
- R3: While `ldac_n` is high (after synchronization), both live registers keep their values, whatever writes arrive.
- R4: `ldac_n` passes through two synchronizer flops. A pending channel's live register (code, gain and mode) takes its staging word at the third rising edge after `ldac_n` goes low.
- R5: A channel whose staging register has not been written since its live register last loaded is not reloaded, and raises no pulse, even while `ldac_n` is low.
- R6: When both channels are pending, a single low period of `ldac_n` reloads both live registers at the same rising edge.
- R7: While the synchronized `ldac_n` is low, a written word reaches the live register at the rising edge after the write. If a write lands in the same cycle as a reload of that channel, the reload takes the older word and the newer word follows one cycle later.
- R8: `dac_upd[ch]` is high for exactly one cycle after each reload of channel ch, and only then.
- R9: `clr_n` low clears the staging register, live register and pending state of both channels at once, without waiting for a clock. After `clr_n` rises, the clear is released at the second rising edge, and writes are accepted from the third rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_n | input | 1 | Asynchronous active-low clear of both channels |
| ldac_n | input | 1 | Level-sensitive active-low load request (asynchronous) |
| wr_en | input | 1 | One-cycle strobe for a completed write |
| wr_sel | input | 1 | Channel select for the write (0 = A, 1 = B) |
| wr_code | input | 12 | Converter code for the write |
| wr_gain | input | 1 | Gain bit for the write |
| wr_pmode | input | 2 | Power-mode field for the write |
| dac_code | output | 24 | Live codes: [11:0] channel A, [23:12] channel B |
| dac_gain | output | 2 | Live gain bits, bit 0 = A |
| dac_pmode | output | 4 | Live mode fields, [1:0] = A |
| dac_upd | output | 2 | One-cycle reload pulse per channel, bit 0 = A |

## Verification
A new write and a reload of the same channel can fall on the same rising edge. This happens when a second word arrives while the load request is held active and the first word is still pending. The bench provokes it by holding `ldac_n` low and issuing two writes to channel A on consecutive cycles. It then expects the live code to show the first word one cycle after the first write and the second word one cycle after that, with a pulse in each of those two cycles. A second collision is tested between the asynchronous clear and a pending word: after the clear, a new load request must move nothing.

// File: rtl/dac_buf_pkg.sv
package dac_buf_pkg;
  // Power-mode field carried with every code word.
  typedef enum logic [1:0] {
    PM_ACTIVE  = 2'd0,
    PM_PULL_1K = 2'd1,
    PM_PULL_HI = 2'd2,
    PM_FLOAT   = 2'd3
  } pmode_e;

  localparam int PMODE_W = 2;
  localparam int GAIN_W  = 1;
endpackage

// File: rtl/dac_buf_sync.sv
module dac_buf_sync #(
  parameter int   STAGES = 2,
  parameter logic IDLE   = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{IDLE}};
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/dac_buf_clr_bridge.sv
module dac_buf_clr_bridge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clr_n,
  output logic clr_int
);
  logic [STAGES-1:0] hold;

  // Asserts the moment clr_n falls; releases after STAGES rising edges.
  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)   hold <= '1;
    else if (rst) hold <= '0;
    else          hold <= {hold[STAGES-2:0], 1'b0};
  end

  assign clr_int = hold[STAGES-1];
endmodule

// File: rtl/dac_buf_slot.sv
module dac_buf_slot #(
  parameter int WORD_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              wr,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              go,
  output logic [WORD_W-1:0] live_word,
  output logic              upd
);
  logic [WORD_W-1:0] stage_word;
  logic              pending;
  logic              reload;

  // Reload only a channel written since its last reload (R5).
  assign reload = go && pending;

  always_ff @(posedge clk or posedge clr) begin
    if (clr) begin
      stage_word <= '0;
      live_word  <= '0;
      pending    <= 1'b0;
      upd        <= 1'b0;
    end else if (rst) begin
      stage_word <= '0;
      live_word  <= '0;
      pending    <= 1'b0;
      upd        <= 1'b0;
    end else begin
      upd <= reload;
      if (reload) begin
        live_word <= stage_word;
        pending   <= 1'b0;
      end
      // A write in the same cycle keeps the channel pending (R7).
      if (wr) begin
        stage_word <= wr_word;
        pending    <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dac_dual_buffer.sv
module dac_dual_buffer #(
  parameter int NCH      = 2,
  parameter int CODE_W   = 12,
  parameter int SYNC_LEN = 2,
  parameter int SEL_W    = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clr_n,
  input  logic                  ldac_n,
  input  logic                  wr_en,
  input  logic [SEL_W-1:0]      wr_sel,
  input  logic [CODE_W-1:0]     wr_code,
  input  logic                  wr_gain,
  input  logic [1:0]            wr_pmode,
  output logic [NCH*CODE_W-1:0] dac_code,
  output logic [NCH-1:0]        dac_gain,
  output logic [2*NCH-1:0]      dac_pmode,
  output logic [NCH-1:0]        dac_upd
);
  import dac_buf_pkg::*;

  localparam int WORD_W = CODE_W + PMODE_W + GAIN_W;

  logic              clr_int;
  logic              ldac_s;
  logic              ldac_go;
  logic [WORD_W-1:0] wr_word;

  dac_buf_clr_bridge #(.STAGES(SYNC_LEN)) u_clr (
    .clk(clk), .rst(rst), .clr_n(clr_n), .clr_int(clr_int)
  );

  dac_buf_sync #(.STAGES(SYNC_LEN), .IDLE(1'b1)) u_ldac (
    .clk(clk), .rst(rst), .din(ldac_n), .dout(ldac_s)
  );

  assign ldac_go = !ldac_s;
  assign wr_word = {wr_gain, wr_pmode, wr_code};

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic              hit;
    logic [WORD_W-1:0] live;

    assign hit = wr_en && (wr_sel == SEL_W'(ch));

    dac_buf_slot #(.WORD_W(WORD_W)) u_slot (
      .clk(clk), .rst(rst), .clr(clr_int),
      .wr(hit), .wr_word(wr_word), .go(ldac_go),
      .live_word(live), .upd(dac_upd[ch])
    );

    assign dac_code[ch*CODE_W +: CODE_W] = live[CODE_W-1:0];
    assign dac_pmode[2*ch +: 2]          = live[CODE_W +: PMODE_W];
    assign dac_gain[ch]                  = live[WORD_W-1];
  end
endmodule

// File: rtl/dac_dual_buffer_chk.sv
module dac_dual_buffer_chk #(
  parameter int NCH    = 2,
  parameter int CODE_W = 12
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  clr_int,
  input logic                  ldac_go,
  input logic [NCH*CODE_W-1:0] dac_code,
  input logic [NCH-1:0]        dac_upd
);
  // R3: an inactive load request freezes the live codes.
  p_hold_r3: assert property (@(posedge clk) disable iff (rst || clr_int)
    !ldac_go |=> $stable(dac_code));

  // R9: while the clear is held, everything visible reads zero.
  p_clear_r9: assert property (@(posedge clk) disable iff (rst)
    clr_int |-> (dac_code == '0 && dac_upd == '0));

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chk
    // R5: a pulse only follows an active load request.
    p_pulse_needs_go_r5: assert property (@(posedge clk) disable iff (rst || clr_int)
      dac_upd[ch] |-> $past(ldac_go));

    // R8: the live code moves only in a pulse cycle.
    p_quiet_r8: assert property (@(posedge clk) disable iff (rst || clr_int)
      (!dac_upd[ch] && !$past(rst) && !$past(clr_int))
        |-> $stable(dac_code[ch*CODE_W +: CODE_W]));
  end
endmodule

bind dac_dual_buffer dac_dual_buffer_chk #(.NCH(NCH), .CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst(rst), .clr_int(clr_int), .ldac_go(ldac_go),
  .dac_code(dac_code), .dac_upd(dac_upd)
);

// File: tb/dac_dual_buffer_test.sv
`timescale 1ns/1ps
module dac_dual_buffer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        clr_n = 1'b1;
  logic        ldac_n = 1'b1;
  logic        wr_en = 1'b0;
  logic [0:0]  wr_sel = '0;
  logic [11:0] wr_code = '0;
  logic        wr_gain = 1'b0;
  logic [1:0]  wr_pmode = '0;
  logic [23:0] dac_code;
  logic [1:0]  dac_gain;
  logic [3:0]  dac_pmode;
  logic [1:0]  dac_upd;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int pulses [2];
  int last_pulse [2];
  bit done = 1'b0;

  always #2 clk = ~clk;

  dac_dual_buffer uut (
    .clk(clk), .rst(rst), .clr_n(clr_n), .ldac_n(ldac_n),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_code(wr_code), .wr_gain(wr_gain),
    .wr_pmode(wr_pmode), .dac_code(dac_code), .dac_gain(dac_gain),
    .dac_pmode(dac_pmode), .dac_upd(dac_upd)
  );

  // Pulse monitor, sampled away from the active edge.
  always @(negedge clk) begin
    cyc <= cyc + 1;
    for (int i = 0; i < 2; i++) if (dac_upd[i]) begin
      pulses[i]     <= pulses[i] + 1;
      last_pulse[i] <= cyc;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clr_pulses();
    tick();
    pulses[0] = 0; pulses[1] = 0;
  endtask

  task automatic write(input int sel, input logic [11:0] code, input logic g, input logic [1:0] pm);
    wr_en = 1'b1; wr_sel = 1'(sel); wr_code = code; wr_gain = g; wr_pmode = pm;
    tick();
    wr_en = 1'b0;
  endtask

  function automatic logic [11:0] code_of(input int ch);
    return dac_code[ch*12 +: 12];
  endfunction

  task automatic t_reset();
    rst = 1'b1; tick(4); rst = 1'b0; tick();
    chk("R1 code after reset", 32'(dac_code), 0);
    chk("R1 gain/mode after reset", {dac_gain, dac_pmode}, 0);
    chk("R1 no pulse after reset", 32'(dac_upd), 0);
  endtask

  task automatic t_hold();
    clr_pulses();
    write(0, 12'hABC, 1'b1, 2'd2);
    tick(5);
    chk("R3 A held while ldac high", 32'(code_of(0)), 0);
    chk("R2 B untouched by A write", 32'(code_of(1)), 0);
    write(1, 12'h123, 1'b0, 2'd1);
    tick(3);
    chk("R3 no pulses while ldac high", pulses[0] + pulses[1], 0);
  endtask

  task automatic t_simul();
    clr_pulses();
    ldac_n = 1'b0;
    tick(2);
    chk("R4 A unchanged after two edges", 32'(code_of(0)), 0);
    tick();
    chk("R4 A code at third edge", 32'(code_of(0)), 32'h ABC);
    chk("R6 B code at same edge", 32'(code_of(1)), 32'h123);
    chk("R4 gain bits", 32'(dac_gain), 32'b01);
    chk("R4 mode fields", 32'(dac_pmode), 32'b0110);
    ldac_n = 1'b1;
    tick(4);
    chk("R6 same reload cycle", 32'(last_pulse[0] == last_pulse[1]), 1);
    chk("R8 one pulse on A", pulses[0], 1);
    chk("R8 one pulse on B", pulses[1], 1);
  endtask

  task automatic t_dirty();
    clr_pulses();
    write(0, 12'h555, 1'b0, 2'd0);
    ldac_n = 1'b0;
    tick(6);
    ldac_n = 1'b1;
    tick(3);
    chk("R4 A reloaded", 32'(code_of(0)), 32'h555);
    chk("R5 B not reloaded", 32'(code_of(1)), 32'h123);
    chk("R5 no pulse on B", pulses[1], 0);
    chk("R8 single pulse on A for level hold", pulses[0], 1);
  endtask

  task automatic t_transparent();
    ldac_n = 1'b0;
    tick(3);
    clr_pulses();
    tick(2);
    chk("R5 nothing pending, no pulse", pulses[0] + pulses[1], 0);
    wr_en = 1'b1; wr_sel = 1'b0; wr_code = 12'h111; wr_gain = 1'b0; wr_pmode = 2'd0;
    tick();
    chk("R7 staged only at write edge", 32'(code_of(0)), 32'h555);
    wr_code = 12'h222;
    tick();
    wr_en = 1'b0;
    chk("R7 first word follows next edge", 32'(code_of(0)), 32'h111);
    chk("R8 pulse with first word", 32'(dac_upd), 32'b01);
    tick();
    chk("R7 colliding word one cycle later", 32'(code_of(0)), 32'h222);
    chk("R8 pulse with second word", 32'(dac_upd), 32'b01);
    tick();
    chk("R8 pulse drops after reload", 32'(dac_upd), 0);
    ldac_n = 1'b1;
    tick(3);
  endtask

  task automatic t_route();
    clr_pulses();
    write(1, 12'h0F0, 1'b1, 2'd3);
    ldac_n = 1'b0;
    tick(5);
    ldac_n = 1'b1;
    tick(3);
    chk("R2 sel 1 reaches B", 32'(code_of(1)), 32'h0F0);
    chk("R2 A unchanged by B write", 32'(code_of(0)), 32'h222);
    chk("R2 no pulse on A", pulses[0], 0);
  endtask

  task automatic t_clear();
    write(0, 12'h777, 1'b1, 2'd1);
    #1 clr_n = 1'b0;
    #1;
    chk("R9 codes cleared without clock", 32'(dac_code), 0);
    chk("R9 gain/mode cleared", {dac_gain, dac_pmode}, 0);
    tick(2);
    clr_n = 1'b1;
    tick(3);
    clr_pulses();
    ldac_n = 1'b0;
    tick(6);
    ldac_n = 1'b1;
    tick(3);
    chk("R9 pending state cleared", pulses[0] + pulses[1], 0);
    chk("R9 codes still zero", 32'(dac_code), 0);
  endtask

  task automatic t_sync_reset();
    write(0, 12'h3C3, 1'b0, 2'd0);
    ldac_n = 1'b0;
    tick(5);
    ldac_n = 1'b1;
    tick(3);
    chk("R4 reload before reset", 32'(code_of(0)), 32'h3C3);
    write(1, 12'h444, 1'b0, 2'd0);
    rst = 1'b1; tick(); rst = 1'b0;
    chk("R1 reset clears live codes", 32'(dac_code), 0);
    clr_pulses();
    ldac_n = 1'b0;
    tick(6);
    ldac_n = 1'b1;
    tick(3);
    chk("R1 reset clears pending state", pulses[0] + pulses[1], 0);
  endtask

  initial begin
    t_reset();
    t_hold();
    t_simul();
    t_dirty();
    t_transparent();
    t_route();
    t_clear();
    t_sync_reset();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule